// File: doc/BRIEF.md
# Round-Robin Position Accuracy Self-Test Monitor

This block checks the accuracy of a set of position output channels, one at a time, while the outputs are in service. It visits each active channel in turn and stays on it for a fixed number of clock cycles. During that interval it compares the measured position with the commanded position. A channel is flagged when the two differ by more than a fixed tolerance at any cycle of the interval. The tolerance is 0.2% of full scale, which is 131 codes for 16-bit positions. If the command itself moves by more than the tolerance during the interval, the result of that interval is discarded, because the measured value lags behind a moving target.

Flags are sticky. A failure that lasts only one cycle still sets the channel's status bit, and the bit stays set until software reads the status word. The read clears only the bits it returned. A bit set in the same cycle as the read is kept. Each channel also has an interrupt enable bit. The interrupt output is a level: it is high while any enabled channel has its status bit set.

The tolerance and the dwell length are parameters. Bus decoding, the analog measurement and the delivery of the interrupt vector are handled outside this block.

Top module: `acc_selftest_mon`

## Requirements
- R1: After reset, the status word reads 0, all interrupt enables are 0, and `irq` is low.
- R2: The monitor dwells on one active channel for exactly DWELL cycles and then moves to the next active channel in increasing index order, wrapping around. Inactive channels are skipped. When no channel is active, the monitor waits.
- R3: A dwell fails when |meas − cmd| for the visited channel is greater than TOL in at least one of its cycles. A difference of exactly TOL (131) passes and TOL+1 (132) fails. A failure lasting a single cycle is enough.
- R4: A dwell records no failure if, in any of its cycles, the visited channel's command differs by more than TOL from the command seen in the dwell's first cycle.
- R5: A status bit, once set, stays set until `rd_stb` is high for a cycle. That read clears only the bits that `rd_data` showed in that cycle. A failure recorded in the same cycle as the read stays set.
- R6: A channel whose `act_mask` bit is 0 reads 0 in the status word from the next cycle on. A channel that becomes inactive during its dwell ends that dwell with no flag.
- R7: Channel i is reported at bit i of the 16-bit `rd_data`. All bits at and above NCH read 0.
- R8: `en_we` loads `en_wdata[NCH-1:0]` as the per-channel interrupt enables. `irq` is high exactly when some channel has both its status bit and its enable bit set.
- R9: A failing dwell sets its status bit in the cycle right after the dwell's last cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_pos | input | NCH*PW | Commanded positions; channel i in bits [i*PW +: PW] |
| meas_pos | input | NCH*PW | Measured positions; channel i in bits [i*PW +: PW] |
| act_mask | input | NCH | Active channel mask; bit i = channel i |
| rd_stb | input | 1 | Status read strobe; clears the returned bits |
| en_we | input | 1 | Write strobe for the interrupt enable register |
| en_wdata | input | 16 | Enable write data; bit i = channel i |
| rd_data | output | 16 | Status word; bit i = 1 means channel i failed |
| irq | output | 1 | Level interrupt, OR of status bits masked by the enables |

## Verification
The main function is tried with four kinds of input, and each one separates a different behaviour.

- **Fixed offsets of exactly 131 and 132 codes.** These pin the tolerance boundary, so an off-by-one error in the compare shows up.
- **A command that ramps every cycle while the measurement lags one step behind.** This produces an error on every cycle that should still be suppressed. It tells the step rule apart from the plain error check.
- **Changes to the active mask.** Faulty channels are dropped from the mask, and one channel is deactivated while its status bit is set. This tests both skipping and the zero reporting of inactive channels.
- **Long random mix.** Offsets lie near and far from the tolerance, with single-cycle spikes, random reads and enable writes. A cycle-by-cycle reference model checks the exact cycle each bit sets and clears. This includes reads that land on the same cycle as a new failure.

// File: rtl/acc_mon_pkg.sv
package acc_mon_pkg;

  // Unsigned magnitude compare: |a - b| > tol, all operands zero-extended to 32 bits
  function automatic logic beyond_tol(input logic [31:0] a, input logic [31:0] b,
                                      input logic [31:0] tol);
    logic [31:0] diff;
    diff = (a >= b) ? (a - b) : (b - a);
    return diff > tol;
  endfunction

endpackage

// File: rtl/acc_rr_seq.sv
module acc_rr_seq #(
  parameter int NCH   = 2,
  parameter int DWELL = 22_500_000,
  localparam int IW   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int CW   = $clog2(DWELL + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NCH-1:0] act,
  output logic [IW-1:0] cur_o,
  output logic          run_o,
  output logic          first_o,
  output logic          last_o
);

  localparam logic [CW-1:0] LAST = CW'(DWELL - 1);

  logic [IW-1:0] cur_q, cur_d, nxt;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          run, last;

  assign run  = act[cur_q];
  assign last = run && (cnt_q == LAST);

  // Nearest active channel after the current one, wrapping; stays put if none
  always_comb begin
    int idx;
    nxt = cur_q;
    for (int k = NCH - 1; k >= 1; k--) begin
      idx = (int'(cur_q) + k) % NCH;
      if (act[idx]) nxt = IW'(idx);
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    cur_d = cur_q;
    if (!run) begin
      cnt_d = '0;
      cur_d = nxt;
    end else if (last) begin
      cnt_d = '0;
      cur_d = nxt;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      cnt_q <= '0;
    end else begin
      cur_q <= cur_d;
      cnt_q <= cnt_d;
    end
  end

  assign cur_o   = cur_q;
  assign run_o   = run;
  assign first_o = (cnt_q == '0);
  assign last_o  = last;

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R2

  AST_WRAP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |=> (cnt_q == '0)); // R2

  AST_ABORT_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !run_o |=> (cnt_q == '0)); // R6

endmodule

// File: rtl/acc_dwell_chk.sv
module acc_dwell_chk
  import acc_mon_pkg::*;
#(
  parameter int PW  = 16,
  parameter int TOL = 131
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] cmd,
  input  logic [PW-1:0] meas,
  input  logic          run,
  input  logic          first,
  input  logic          last,
  output logic          fail_o
);

  localparam logic [31:0] TOL32 = 32'(TOL);

  logic [PW-1:0] ref_q, ref_eff;
  logic          err_q, step_q;
  logic          err_now, step_now, err_eff, step_eff;

  // The command seen in the first cycle of a dwell is the reference
  assign ref_eff  = first ? cmd : ref_q;
  assign err_now  = beyond_tol(32'(meas), 32'(cmd), TOL32);
  assign step_now = beyond_tol(32'(cmd), 32'(ref_eff), TOL32);
  assign err_eff  = (first ? 1'b0 : err_q) | err_now;
  assign step_eff = (first ? 1'b0 : step_q) | step_now;

  // Clock enable: accumulate only while an active channel is being visited
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q  <= '0;
      err_q  <= 1'b0;
      step_q <= 1'b0;
    end else if (run) begin
      ref_q  <= ref_eff;
      err_q  <= err_eff;
      step_q <= step_eff;
    end
  end

  assign fail_o = last && err_eff && !step_eff;

  AST_FAIL_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |-> (run && last)); // R9

endmodule

// File: rtl/acc_stat_reg.sv
module acc_stat_reg #(
  parameter int NCH = 2,
  parameter int SW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] act,
  input  logic [NCH-1:0] set_vec,
  input  logic           rd_stb,
  input  logic           en_we,
  input  logic [SW-1:0]  en_wdata,
  output logic [SW-1:0]  rd_data,
  output logic           irq
);

  logic [NCH-1:0] sticky_q, sticky_d, clr_vec;
  logic [NCH-1:0] en_q, en_d;

  // Only the bits returned in the reading cycle are cleared; new sets win
  assign clr_vec  = rd_stb ? sticky_q : '0;
  assign sticky_d = ((sticky_q & ~clr_vec) | set_vec) & act;
  assign en_d     = en_wdata[NCH-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sticky_q <= '0;
    else        sticky_q <= sticky_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_we) en_q <= en_d;
  end

  assign rd_data = SW'(sticky_q);
  assign irq     = |(sticky_q & en_q);

  AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_vec & act)) |=> ((sticky_q & $past(set_vec & act)) == $past(set_vec & act))); // R5

  AST_HOLD_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> ((($past(sticky_q) & $past(act)) & ~sticky_q) == '0)); // R5

  AST_INACTIVE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sticky_q & ~$past(act)) == '0)); // R6

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(en_we || (|set_vec))); // R8

endmodule

// File: rtl/acc_selftest_mon.sv
module acc_selftest_mon #(
  parameter int NCH   = 2,
  parameter int PW    = 16,
  parameter int TOL   = 131,
  parameter int DWELL = 22_500_000,
  parameter int SW    = 16,
  localparam int IW   = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH*PW-1:0] cmd_pos,
  input  logic [NCH*PW-1:0] meas_pos,
  input  logic [NCH-1:0]    act_mask,
  input  logic              rd_stb,
  input  logic              en_we,
  input  logic [SW-1:0]     en_wdata,
  output logic [SW-1:0]     rd_data,
  output logic              irq
);

  logic [IW-1:0]  cur;
  logic           run, first, last, fail;
  logic [PW-1:0]  cmd_sel, meas_sel;
  logic [NCH-1:0] set_vec;

  acc_rr_seq #(.NCH(NCH), .DWELL(DWELL)) u_seq (
    .clk(clk), .rst_n(rst_n), .act(act_mask),
    .cur_o(cur), .run_o(run), .first_o(first), .last_o(last)
  );

  always_comb begin
    cmd_sel  = '0;
    meas_sel = '0;
    for (int i = 0; i < NCH; i++) begin
      if (cur == IW'(i)) begin
        cmd_sel  = cmd_pos[i*PW +: PW];
        meas_sel = meas_pos[i*PW +: PW];
      end
    end
  end

  acc_dwell_chk #(.PW(PW), .TOL(TOL)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd(cmd_sel), .meas(meas_sel),
    .run(run), .first(first), .last(last), .fail_o(fail)
  );

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_set
      assign set_vec[g] = fail && (cur == IW'(g));
    end
  endgenerate

  acc_stat_reg #(.NCH(NCH), .SW(SW)) u_stat (
    .clk(clk), .rst_n(rst_n), .act(act_mask), .set_vec(set_vec),
    .rd_stb(rd_stb), .en_we(en_we), .en_wdata(en_wdata),
    .rd_data(rd_data), .irq(irq)
  );

  AST_ONE_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(set_vec)); // R2

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data >> NCH) == '0); // R7

endmodule

// File: tb/sim_acc_selftest_mon.sv
`timescale 1ns/1ps
module sim_acc_selftest_mon;
  localparam int NCH = 3, PW = 16, TOL = 131, DWELL = 12, SW = 16;
  localparam int SWEEP = NCH * DWELL;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n;
  logic [NCH*PW-1:0] cmd_pos, meas_pos;
  logic [NCH-1:0]    act_mask;
  logic              rd_stb, en_we;
  logic [SW-1:0]     en_wdata, rd_data;
  logic              irq;
  int                cmd_a [NCH];
  int                meas_a[NCH];

  always_comb
    for (int i = 0; i < NCH; i++) begin
      cmd_pos[i*PW +: PW]  = PW'(cmd_a[i]);
      meas_pos[i*PW +: PW] = PW'(meas_a[i]);
    end

  acc_selftest_mon #(.NCH(NCH), .PW(PW), .TOL(TOL), .DWELL(DWELL), .SW(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_pos(cmd_pos), .meas_pos(meas_pos),
    .act_mask(act_mask), .rd_stb(rd_stb), .en_we(en_we), .en_wdata(en_wdata),
    .rd_data(rd_data), .irq(irq)
  );

  int    n_chk = 0, n_fail = 0;
  string tag = "R1";
  bit    live = 0;

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", what, act, exp, $time);
    end
  endtask

  function automatic bit over(int a, int b);
    int d;
    d = (a & 16'hFFFF) - (b & 16'hFFFF);
    if (d < 0) d = -d;
    return d > TOL;
  endfunction

  // Reference model from the requirements
  int m_cur, m_cnt, m_ref;
  bit m_err, m_step;
  logic [NCH-1:0] m_sticky, m_en;

  function automatic int next_act(int c, logic [NCH-1:0] a);
    for (int k = 1; k < NCH; k++)
      if (a[(c + k) % NCH]) return (c + k) % NCH;
    return c;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cur = 0; m_cnt = 0; m_ref = 0; m_err = 0; m_step = 0;
      m_sticky = '0; m_en = '0;
    end else begin : mdl
      logic [NCH-1:0] setv;
      int c, r;
      bit e, s;
      setv = '0;
      if (act_mask[m_cur]) begin
        c = cmd_a[m_cur] & 16'hFFFF;
        r = (m_cnt == 0) ? c : m_ref;
        e = ((m_cnt == 0) ? 1'b0 : m_err) | over(meas_a[m_cur], c);
        s = ((m_cnt == 0) ? 1'b0 : m_step) | over(c, r);
        m_ref = r; m_err = e; m_step = s;
        if (m_cnt == DWELL - 1) begin
          if (e && !s) setv[m_cur] = 1'b1;
          m_cnt = 0;
          m_cur = next_act(m_cur, act_mask);
        end else m_cnt++;
      end else begin
        m_cnt = 0;
        m_cur = next_act(m_cur, act_mask);
      end
      m_sticky = ((m_sticky & ~(rd_stb ? m_sticky : '0)) | setv) & act_mask;
      if (en_we) m_en = en_wdata[NCH-1:0];
    end
  end

  always @(negedge clk) if (live) begin
    chk($sformatf("%s status vs model", tag), 32'(rd_data), 32'(m_sticky));
    chk($sformatf("%s irq vs model", tag), 32'(irq), 32'(|(m_sticky & m_en)));
    chk("R7 upper bits zero", 32'(rd_data >> NCH), 32'd0);
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
    rd_stb = 0; en_we = 0;
  endtask

  task automatic set_all(int c);
    for (int i = 0; i < NCH; i++) begin cmd_a[i] = c; meas_a[i] = c; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 0; rd_stb = 0; en_we = 0; en_wdata = '0; act_mask = '1;
    set_all(1000);
    repeat (3) @(negedge clk);
    chk("R1 reset status", 32'(rd_data), 0);
    chk("R1 reset irq", 32'(irq), 0);
    rst_n = 1; live = 1;
    step(2);
    chk("R1 enables zero after reset", 32'(irq), 0);

    // Tolerance boundary: 131 passes, 132 fails
    tag = "R3 boundary";
    meas_a[0] = 1131; meas_a[1] = 868;
    step(4 * SWEEP);
    chk("R3 R7 boundary status word", 32'(rd_data), 32'h2);
    chk("R8 masked irq", 32'(irq), 0);

    // Enable, then fix the fault and read
    tag = "R8 enable";
    en_we = 1; en_wdata = 16'h0002; step(1);
    step(1);
    chk("R8 irq after enable", 32'(irq), 1);
    meas_a[1] = 1000;
    step(2 * SWEEP + 2);
    tag = "R5 read clear";
    rd_stb = 1; step(1);
    chk("R5 status after read", 32'(rd_data), 0);
    chk("R5 irq after read", 32'(irq), 0);

    // Command ramps every cycle; lagging measurement must be suppressed
    tag = "R4 ramp";
    for (int t = 0; t < 3 * SWEEP; t++) begin
      meas_a[1] = cmd_a[1];
      cmd_a[1]  = (cmd_a[1] + 200) & 16'hFFFF;
      step(1);
    end
    chk("R4 no flag while command steps", 32'(rd_data), 0);
    meas_a[1] = cmd_a[1];
    step(SWEEP);

    // Inactive channels
    tag = "R6 inactive";
    meas_a[0] = 1500;
    step(2 * SWEEP);
    chk("R3 channel 0 flagged", 32'(rd_data[0]), 1);
    act_mask = 3'b110; step(1);
    chk("R6 deactivated channel reads 0", 32'(rd_data[0]), 0);
    meas_a[0] = 1000; meas_a[2] = 3000; act_mask = 3'b011;
    step(3 * SWEEP);
    chk("R6 inactive faulty channel not flagged", 32'(rd_data[2]), 0);
    act_mask = '0; step(SWEEP);
    chk("R2 idle with no active channel", 32'(rd_data), 0);
    act_mask = '1; meas_a[2] = 1000; step(2 * SWEEP);
    rd_stb = 1; step(1);

    // Random mix
    tag = "R2 R5 R9 random";
    for (int t = 0; t < 4000; t++) begin
      for (int i = 0; i < NCH; i++) begin
        int r, off;
        if ($urandom % 20 == 0) cmd_a[i] = (cmd_a[i] + int'($urandom % 301) - 150) & 16'hFFFF;
        r = $urandom % 100;
        if (r < 70)      off = int'($urandom % 261) - 130;
        else if (r < 90) off = ($urandom % 2 ? 131 : 132) * ($urandom % 2 ? 1 : -1);
        else             off = int'($urandom % 2001) - 1000;
        meas_a[i] = (cmd_a[i] + off) & 16'hFFFF;
      end
      if ($urandom % 50 == 0) act_mask = NCH'($urandom);
      rd_stb = ($urandom % 8 == 0);
      if ($urandom % 25 == 0) begin en_we = 1; en_wdata = 16'($urandom); end
      @(negedge clk);
      en_we = 0; rd_stb = 0;
    end

    live = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule